// File: doc/BRIEF.md
# Eight-Link Stream FIFO Controller with Per-Link Interrupts

This block sits on a simple word-addressed register bus. It connects a processor to eight inbound and eight outbound word streams. Each link, in each direction, has its own small FIFO.

Inbound words arrive on a valid/ready port and wait in the link's receive FIFO until software reads that link's data window. Words that software writes to a data window queue in the link's transmit FIFO until the stream consumer takes them on the outbound valid/ready port.

A read-only status word gives fill information for every link. Two interrupt lines summarise the links: one for the receive side and one for the transmit side. Each link can be enabled or masked on its own interrupt line, and each link selects which fill condition raises it. A single global enable, while clear, keeps every FIFO empty and both interrupt lines quiet.

Top module: `stream_link_irq_ctrl`

## Requirements
- R1: After reset, the control word reads `0` in bit 31, the interrupt configuration reads 0, the status word reads `0x0000FF00`, both interrupt lines are low and every `rxReady` is low.
- R2: Control word (byte offset 0). Bit 31 is the global enable and is read/write. Bits 11:8 read the log2 of the receive FIFO depth and bits 15:12 read the log2 of the transmit FIFO depth; both are read-only. All other bits read 0.
- R3: Interrupt configuration (byte offset 8) is read/write. Bits 7:0 are the per-link receive enables, 15:8 the receive modes, 23:16 the transmit enables and 31:24 the transmit modes, with bit n of each field belonging to link n.
- R4: Status word (byte offset 16). Bit n (0..7) is set when receive FIFO n holds data. Bit 8+n is set when transmit FIFO n is not full. Bit 16+n is set when receive FIFO n holds at least half its depth. Bits 31:24 read 0.
- R5: A bus write to data window n (byte offset 32+4n) pushes the written word into transmit FIFO n. A write to a full FIFO is dropped and leaves it unchanged.
- R6: A bus read of data window n returns the oldest word of receive FIFO n and removes it. A read of an empty FIFO returns 0 and removes nothing.
- R7: `rxReady[n]` is high exactly when the global enable is set and receive FIFO n is not full. A word is stored when `rxValid[n]` and `rxReady[n]` are both high at a clock edge.
- R8: `txValid[n]` is high exactly when transmit FIFO n holds data, and `txData` lane n shows its oldest word. That word is removed when `txReady[n]` is high at a clock edge. Words leave in the order they were written.
- R9: `rxIrq` is high when the global enable is set and some link n has its receive enable set and its condition true. With mode bit 0 the condition is FIFO at least half full; with mode bit 1 it is FIFO not empty.
- R10: `txIrq` is high when the global enable is set and some link n has its transmit enable set and its condition true. With mode bit 0 the condition is FIFO holding fewer than half its depth; with mode bit 1 it is FIFO not full.
- R11: While the global enable is clear, all FIFOs are empty, data-window writes and inbound words are discarded, and both interrupt lines stay low.
- R12: Read data appears on `busRdata` at the clock edge that samples `busRe`. A write to the status word or to an unmapped offset changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 6 | Byte address of the register access |
| busWe | input | 1 | Write strobe |
| busRe | input | 1 | Read strobe |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, registered |
| rxValid | input | 8 | Inbound word valid, one bit per link |
| rxData | input | 256 | Inbound words, lane n in bits 32n+31:32n |
| rxReady | output | 8 | Inbound FIFO can accept, one bit per link |
| txValid | output | 8 | Outbound word available, one bit per link |
| txData | output | 256 | Outbound words, lane n in bits 32n+31:32n |
| txReady | input | 8 | Outbound consumer takes the word, one bit per link |
| rxIrq | output | 1 | Combined receive interrupt |
| txIrq | output | 1 | Combined transmit interrupt |

## Verification
The bench builds the block with a receive depth of 4 (log2 2) and a transmit depth of 8 (log2 3). The two sides therefore have different half-way thresholds and different values in the read-only depth fields.

The shallow receive FIFOs reach full, half and empty within a few random operations, so `rxReady` back-pressure and both receive interrupt modes occur often. A directed burst of ten writes into one transmit FIFO reaches the full-drop case, and a drain afterwards checks ordering. Random toggling of the global enable exercises the flush in the middle of traffic.

// File: rtl/slc_pkg.sv
package slc_pkg;
  localparam int LINKS  = 8;
  localparam int WORD_W = 32;

  // strobes from the register control to the FIFO datapath
  typedef struct packed {
    logic [LINKS-1:0]  txPush;
    logic [LINKS-1:0]  rxPop;
    logic              flush;
    logic [WORD_W-1:0] pushData;
  } strobeT;
endpackage

// File: rtl/slc_fifo.sv
module slc_fifo #(
  parameter int W  = 32,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          flush,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  wData,
  output logic [W-1:0]  rData,
  output logic [AW:0]   level
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic          full, empty, doPush, doPop;

  assign full   = (level == (AW+1)'(DEPTH));
  assign empty  = (level == '0);
  assign doPush = push & ~full;
  assign doPop  = pop & ~empty;
  assign rData  = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush && !flush) mem[wrPtr] <= wData;
  end

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (doPush) wrPtr <= wrPtr + 1'b1;
      if (doPop)  rdPtr <= rdPtr + 1'b1;
      level <= level + (AW+1)'(doPush) - (AW+1)'(doPop);
    end
  end

  // R5
  level_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    level <= (AW+1)'(DEPTH));

  // R5
  full_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (full && push && !pop && !flush) |=> level == (AW+1)'(DEPTH));

  // R6
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (empty && pop && !push) |=> level == '0);
endmodule

// File: rtl/slc_datapath.sv
module slc_datapath
  import slc_pkg::*;
#(
  parameter int RX_L2 = 2,
  parameter int TX_L2 = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobeT                  strobes,
  input  logic [31:0]             cfg,
  input  logic [LINKS-1:0]        rxValid,
  input  logic [LINKS*WORD_W-1:0] rxData,
  output logic [LINKS-1:0]        rxReady,
  output logic [LINKS-1:0]        txValid,
  output logic [LINKS*WORD_W-1:0] txData,
  input  logic [LINKS-1:0]        txReady,
  output logic [LINKS*WORD_W-1:0] rxHead,
  output logic [31:0]             status,
  output logic                    rxIrq,
  output logic                    txIrq
);
  localparam int RXD = 1 << RX_L2;
  localparam int TXD = 1 << TX_L2;

  logic [LINKS-1:0] rxAvail, rxHalf, txNotFull, txLow, rxHit, txHit;

  for (genvar i = 0; i < LINKS; i++) begin : gLink
    logic [RX_L2:0] rxLvl;
    logic [TX_L2:0] txLvl;

    slc_fifo #(.W(WORD_W), .AW(RX_L2)) u_rx (
      .clk(clk), .rstN(rstN), .flush(strobes.flush),
      .push(rxValid[i] & rxReady[i]), .pop(strobes.rxPop[i]),
      .wData(rxData[i*WORD_W +: WORD_W]), .rData(rxHead[i*WORD_W +: WORD_W]),
      .level(rxLvl));

    slc_fifo #(.W(WORD_W), .AW(TX_L2)) u_tx (
      .clk(clk), .rstN(rstN), .flush(strobes.flush),
      .push(strobes.txPush[i]), .pop(txReady[i] & txValid[i]),
      .wData(strobes.pushData), .rData(txData[i*WORD_W +: WORD_W]),
      .level(txLvl));

    assign rxAvail[i]   = (rxLvl != '0);
    assign rxHalf[i]    = (rxLvl >= (RX_L2+1)'(RXD/2));
    assign rxReady[i]   = ~strobes.flush & (rxLvl != (RX_L2+1)'(RXD));
    assign txValid[i]   = (txLvl != '0);
    assign txNotFull[i] = (txLvl != (TX_L2+1)'(TXD));
    assign txLow[i]     = (txLvl < (TX_L2+1)'(TXD/2));

    // per-link condition picked by the mode bit
    assign rxHit[i] = cfg[i]      & (cfg[8+i]  ? rxAvail[i]   : rxHalf[i]);
    assign txHit[i] = cfg[16+i]   & (cfg[24+i] ? txNotFull[i] : txLow[i]);
  end

  assign status = {8'h00, rxHalf, txNotFull, rxAvail};
  assign rxIrq  = ~strobes.flush & (|rxHit);
  assign txIrq  = ~strobes.flush & (|txHit);

  // R11
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.flush |=> (rxAvail == '0) && (txValid == '0));

  // R7
  rx_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid[0] && rxReady[0] && !strobes.rxPop[0]) |=> rxAvail[0]);
endmodule

// File: rtl/slc_control.sv
module slc_control
  import slc_pkg::*;
#(
  parameter int RX_L2 = 2,
  parameter int TX_L2 = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [5:0]              busAddr,
  input  logic                    busWe,
  input  logic                    busRe,
  input  logic [31:0]             busWdata,
  output logic [31:0]             busRdata,
  input  logic [31:0]             status,
  input  logic [LINKS*WORD_W-1:0] rxHead,
  output strobeT                  strobes,
  output logic [31:0]             cfg
);
  logic       enable;
  logic [3:0] word;
  logic       aligned, isCtrl, isCfg, isStat, isData;
  logic [2:0] link;
  logic [31:0] ctrlView, readMux;

  assign word    = busAddr[5:2];
  assign aligned = (busAddr[1:0] == 2'b00);
  assign isCtrl  = aligned & (word == 4'd0);
  assign isCfg   = aligned & (word == 4'd2);
  assign isStat  = aligned & (word == 4'd4);
  assign isData  = aligned & word[3];
  assign link    = word[2:0];

  assign ctrlView = {enable, 15'h0000, 4'(TX_L2), 4'(RX_L2), 8'h00};

  always_comb begin
    strobes.flush    = ~enable;
    strobes.pushData = busWdata;
    for (int i = 0; i < LINKS; i++) begin
      strobes.txPush[i] = busWe & isData & (link == 3'(i));
      strobes.rxPop[i]  = busRe & isData & (link == 3'(i));
    end
  end

  always_comb begin
    readMux = '0;
    if (isCtrl)      readMux = ctrlView;
    else if (isCfg)  readMux = cfg;
    else if (isStat) readMux = status;
    else if (isData) readMux = status[link] ? rxHead[link*WORD_W +: WORD_W] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enable   <= 1'b0;
      cfg      <= '0;
      busRdata <= '0;
    end else begin
      if (busWe && isCtrl) enable <= busWdata[31];
      if (busWe && isCfg)  cfg    <= busWdata;
      if (busRe)           busRdata <= readMux;
    end
  end

  // R12
  status_write_inert_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && isStat) |=> $stable(cfg) && $stable(enable));

  // R2
  ctrl_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && isCtrl) |=> enable == $past(busWdata[31]));
endmodule

// File: rtl/stream_link_irq_ctrl.sv
module stream_link_irq_ctrl
  import slc_pkg::*;
#(
  parameter int RX_DEPTH_LOG2 = 2,
  parameter int TX_DEPTH_LOG2 = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [5:0]   busAddr,
  input  logic         busWe,
  input  logic         busRe,
  input  logic [31:0]  busWdata,
  output logic [31:0]  busRdata,
  input  logic [7:0]   rxValid,
  input  logic [255:0] rxData,
  output logic [7:0]   rxReady,
  output logic [7:0]   txValid,
  output logic [255:0] txData,
  input  logic [7:0]   txReady,
  output logic         rxIrq,
  output logic         txIrq
);
  strobeT                  strobes;
  logic [31:0]             cfg, status;
  logic [LINKS*WORD_W-1:0] rxHead;

  slc_control #(.RX_L2(RX_DEPTH_LOG2), .TX_L2(TX_DEPTH_LOG2)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busRe(busRe),
    .busWdata(busWdata), .busRdata(busRdata), .status(status),
    .rxHead(rxHead), .strobes(strobes), .cfg(cfg));

  slc_datapath #(.RX_L2(RX_DEPTH_LOG2), .TX_L2(TX_DEPTH_LOG2)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cfg(cfg),
    .rxValid(rxValid), .rxData(rxData), .rxReady(rxReady),
    .txValid(txValid), .txData(txData), .txReady(txReady),
    .rxHead(rxHead), .status(status), .rxIrq(rxIrq), .txIrq(txIrq));
endmodule

// File: tb/stream_link_irq_ctrl_tb.sv
module stream_link_irq_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int RXL = 2;
  localparam int TXL = 3;
  localparam int RXD = 1 << RXL;
  localparam int TXD = 1 << TXL;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [5:0]   busAddr = '0;
  logic         busWe = 1'b0, busRe = 1'b0;
  logic [31:0]  busWdata = '0, busRdata;
  logic [7:0]   rxValid = '0, rxReady, txValid, txReady = '0;
  logic [255:0] rxData = '0, txData;
  logic         rxIrq, txIrq;

  int total = 0, bad = 0;
  logic [31:0] rxM [8][RXD];
  logic [31:0] txM [8][TXD];
  int rxN [8];
  int txN [8];
  logic        en = 1'b0;
  logic [31:0] cfgM = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stream_link_irq_ctrl #(.RX_DEPTH_LOG2(RXL), .TX_DEPTH_LOG2(TXL)) u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busRe(busRe),
    .busWdata(busWdata), .busRdata(busRdata), .rxValid(rxValid), .rxData(rxData),
    .rxReady(rxReady), .txValid(txValid), .txData(txData), .txReady(txReady),
    .rxIrq(rxIrq), .txIrq(txIrq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expStatus();
    logic [31:0] s = '0;
    for (int i = 0; i < 8; i++) begin
      s[i]    = rxN[i] > 0;
      s[8+i]  = txN[i] < TXD;
      s[16+i] = rxN[i] >= RXD/2;
    end
    return s;
  endfunction

  function automatic logic expRxIrq();
    logic r = 1'b0;
    for (int i = 0; i < 8; i++)
      if (cfgM[i] && (cfgM[8+i] ? rxN[i] > 0 : rxN[i] >= RXD/2)) r = 1'b1;
    return r & en;
  endfunction

  function automatic logic expTxIrq();
    logic r = 1'b0;
    for (int i = 0; i < 8; i++)
      if (cfgM[16+i] && (cfgM[24+i] ? txN[i] < TXD : txN[i] < TXD/2)) r = 1'b1;
    return r & en;
  endfunction

  function automatic logic [31:0] expCtrl();
    return {en, 15'h0, 4'(TXL), 4'(RXL), 8'h00};
  endfunction

  task automatic flushModel();
    for (int i = 0; i < 8; i++) begin rxN[i] = 0; txN[i] = 0; end
  endtask

  task automatic busWrite(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic busRead(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busRe = 1'b1;
    @(negedge clk);
    busRe = 1'b0;
    d = busRdata;
  endtask

  // R5: data window write with model update
  task automatic winWrite(input int l, input logic [31:0] d);
    busWrite(6'(32 + 4*l), d);
    if (en && txN[l] < TXD) begin txM[l][txN[l]] = d; txN[l]++; end
  endtask

  // R6: data window read with check
  task automatic winRead(input int l);
    logic [31:0] d, e;
    e = (rxN[l] > 0) ? rxM[l][0] : 32'h0;
    busRead(6'(32 + 4*l), d);
    chk("R6 window read", d, e);
    if (rxN[l] > 0) begin
      for (int k = 0; k < RXD-1; k++) rxM[l][k] = rxM[l][k+1];
      rxN[l]--;
    end
  endtask

  // R7: inbound stream word
  task automatic rxPush(input int l, input logic [31:0] d);
    @(negedge clk);
    chk("R7 rxReady", 32'(rxReady[l]), 32'(en && rxN[l] < RXD));
    rxData[l*32 +: 32] = d;
    rxValid[l] = 1'b1;
    @(negedge clk);
    rxValid[l] = 1'b0;
    if (en && rxN[l] < RXD) begin rxM[l][rxN[l]] = d; rxN[l]++; end
  endtask

  // R8: outbound stream take
  task automatic txPop(input int l);
    @(negedge clk);
    chk("R8 txValid", 32'(txValid[l]), 32'(txN[l] > 0));
    if (txN[l] > 0) begin
      chk("R8 txData order", txData[l*32 +: 32], txM[l][0]);
      txReady[l] = 1'b1;
      @(negedge clk);
      txReady[l] = 1'b0;
      for (int k = 0; k < TXD-1; k++) txM[l][k] = txM[l][k+1];
      txN[l]--;
    end
  endtask

  task automatic checkState(input string tag);
    logic [31:0] s;
    busRead(6'd16, s);
    chk({"R4 status ", tag}, s, expStatus());
    chk({"R9 rxIrq ", tag}, 32'(rxIrq), 32'(expRxIrq()));
    chk({"R10 txIrq ", tag}, 32'(txIrq), 32'(expTxIrq()));
    if (!en) chk("R11 irqs quiet", 32'({rxIrq, txIrq}), 32'h0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    void'($urandom(32'd20240611));
    flushModel();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    @(negedge clk);
    chk("R1 rxReady", 32'(rxReady), 32'h0);
    chk("R1 irqs", 32'({rxIrq, txIrq}), 32'h0);
    busRead(6'd0, d);  chk("R1 ctrl", d, 32'h0000_3200);
    busRead(6'd8, d);  chk("R1 cfg", d, 32'h0);
    busRead(6'd16, d); chk("R1 status", d, 32'h0000_FF00);

    // R11 writes while disabled are discarded
    winWrite(2, 32'hDEAD_0001);
    rxPush(1, 32'hDEAD_0002);
    checkState("disabled");

    // R2 enable, other bits ignored
    busWrite(6'd0, 32'hFFFF_FFFF); en = 1'b1;
    busRead(6'd0, d); chk("R2 ctrl read", d, expCtrl());

    // R6 empty read returns zero
    winRead(5);

    // R9 receive modes on link 2
    cfgM = 32'h0000_0004; busWrite(6'd8, cfgM);   // enable rx link 2, mode half
    rxPush(2, 32'hA000_0001);
    checkState("rx one mode0");
    cfgM = 32'h0000_0404; busWrite(6'd8, cfgM);   // mode not-empty
    checkState("rx one mode1");
    cfgM = 32'h0000_0004; busWrite(6'd8, cfgM);
    rxPush(2, 32'hA000_0002);
    checkState("rx half mode0");
    for (int k = 0; k < 4; k++) rxPush(2, 32'hA000_0010 + k);  // overfill
    checkState("rx full");
    for (int k = 0; k < 5; k++) winRead(2);

    // R5 R10 transmit fill past capacity on link 3
    cfgM = 32'h0008_0000; busWrite(6'd8, cfgM);   // tx link 3, mode less-than-half
    checkState("tx empty mode0");
    for (int k = 0; k < 10; k++) winWrite(3, 32'hB000_0000 + k);
    checkState("tx full");
    cfgM = 32'h0808_0000; busWrite(6'd8, cfgM);
    checkState("tx full mode1");
    for (int k = 0; k < 9; k++) txPop(3);
    checkState("tx drained");

    // R12 status write has no effect
    busWrite(6'd16, 32'hFFFF_FFFF);
    busRead(6'd8, d); chk("R12 cfg kept", d, cfgM);
    busRead(6'd0, d); chk("R12 ctrl kept", d, expCtrl());

    // random traffic
    for (int it = 0; it < 1500; it++) begin
      int op = int'($urandom % 8);
      int l  = int'($urandom % 8);
      case (op)
        0, 1: rxPush(l, $urandom);
        2:    winWrite(l, $urandom);
        3, 4: winRead(l);
        5:    txPop(l);
        6: begin
          cfgM = $urandom; busWrite(6'd8, cfgM);
          busRead(6'd8, d); chk("R3 cfg readback", d, cfgM);
        end
        default: begin
          if ($urandom % 6 == 0) begin
            logic [31:0] w = $urandom;
            busWrite(6'd0, w);
            en = w[31];
            if (!en) flushModel();
            busRead(6'd0, d); chk("R2 ctrl readback", d, expCtrl());
          end else begin
            busWrite(6'd16, $urandom);
            busRead(6'd8, d); chk("R12 cfg after status write", d, cfgM);
          end
          if (!en && $urandom % 2 == 0) begin
            busWrite(6'd0, 32'h8000_0000); en = 1'b1;
          end
        end
      endcase
      checkState("random");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule